// File: doc/BRIEF.md
# Host-to-Controller Mailbox Register Block

This block is a register-mapped mailbox between a host processor and an embedded system controller. The host writes up to sixteen bytes of payload into a write buffer and then writes a command word. That command write raises a one-cycle request strobe toward the controller and sets a busy flag in the status register. The controller reads the payload by word index and loads any reply data into a read buffer. It then signals completion with an error flag, an error code and an initiator id.

The host learns of completion in one of two ways. It can poll the busy bit of the status register. Or, if the command word had its interrupt-on-completion bit set, it receives a one-cycle completion pulse that needs no clearing. A command written while the previous one is still busy is dropped, and a sticky overrun flag records the loss. Host reads come back one cycle after the read strobe. They can be whole words, or single bytes placed in bits 7:0.

Top module: `mbox_regblk`

## Requirements
- R1: After reset the status word reads 0, `host_irq` and `ctl_req` are 0, and both buffers hold zero.
- R2: A host write to offset 0x00 while not busy latches the 32-bit command word on `ctl_cmd`. It sets busy (status bit 0), clears error (bit 1) and copies command bits 15:12 into status bits 7:4. `ctl_req` is high for exactly the one following cycle.
- R3: A `ctl_done` pulse while busy clears busy. It loads `ctl_err` into status bit 1, `ctl_init_id` into bits 15:8 and `ctl_err_code` into bits 23:16.
- R4: If bit 8 of the accepted command word was 1, `host_irq` is high for exactly the one cycle after the completing `ctl_done`. If that bit was 0, `host_irq` stays low.
- R5: A command write while busy is ignored: `ctl_cmd` and the status fields stay unchanged and no `ctl_req` follows. Status bit 2 (overrun) is set and stays set until reset.
- R6: Host writes to offsets 0x80, 0x84, 0x88 and 0x8C fill write-buffer words 0 to 3. Word `ctl_wbuf_idx` appears combinationally on `ctl_wbuf_data`.
- R7: `ctl_rbuf_we` loads `ctl_rbuf_data` into read-buffer word `ctl_rbuf_idx`. The host reads word k at offset 0x90+4k. A byte read (`h_byte`=1) of offset 0x90+n returns bits 8*(n%4)+7 : 8*(n%4) of word n/4 in bits 7:0, with the upper bits 0.
- R8: `h_rdata` is loaded one cycle after a cycle with `h_rd_en`. Reads of the command offset, of the write buffer and of any unmapped offset return 0.
- R9: A `ctl_done` pulse while not busy changes no status field and raises no `host_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_wr_en | input | 1 | Host write strobe |
| h_rd_en | input | 1 | Host read strobe |
| h_byte | input | 1 | Host read returns one byte instead of a word |
| h_addr | input | 8 | Host byte offset |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, registered |
| host_irq | output | 1 | One-cycle completion pulse to the host |
| ctl_req | output | 1 | One-cycle request strobe to the controller |
| ctl_cmd | output | 32 | Latched command word |
| ctl_wbuf_idx | input | IDX_W | Controller write-buffer word select |
| ctl_wbuf_data | output | 32 | Selected write-buffer word |
| ctl_rbuf_we | input | 1 | Controller read-buffer load strobe |
| ctl_rbuf_idx | input | IDX_W | Read-buffer word to load |
| ctl_rbuf_data | input | 32 | Read-buffer load data |
| ctl_done | input | 1 | Completion strobe from the controller |
| ctl_err | input | 1 | Error flag given with completion |
| ctl_err_code | input | 8 | Error code given with completion |
| ctl_init_id | input | 8 | Initiator id given with completion |

## Verification
Inputs change at the falling edge, so every registered result is due at the first rising edge after the stimulus. The bench samples it at the falling edge that follows. That rule covers the `ctl_req` strobe and the latched `ctl_cmd` after a command write, the `host_irq` pulse after `ctl_done`, and `h_rdata` after a read strobe. Each pulse is sampled again one cycle later, where it must be low. Status effects of a write or a completion are observed by a status read issued on the next cycle, so that result arrives two edges after the stimulus. `ctl_wbuf_data` is combinational and is checked shortly after its index changes, within the same cycle.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam logic [7:0] OFS_CMD    = 8'h00;
    localparam logic [7:0] OFS_STATUS = 8'h04;
    localparam logic [3:0] WIN_WBUF   = 4'h8;
    localparam logic [3:0] WIN_RBUF   = 4'h9;

    typedef struct packed {
        logic [7:0] rsvd_hi;
        logic [7:0] size;
        logic [3:0] cmd_id;
        logic [2:0] rsvd_lo;
        logic       ioc;
        logic [7:0] opcode;
    } cmd_word_t;

    typedef struct packed {
        logic [7:0] rsvd_hi;
        logic [7:0] err_code;
        logic [7:0] init_id;
        logic [3:0] cmd_id;
        logic       rsvd_b3;
        logic       overrun;
        logic       err;
        logic       busy;
    } status_word_t;

    function automatic logic [7:0] pick_byte(input logic [31:0] w, input logic [1:0] sel);
        return w[8*sel +: 8];
    endfunction

endpackage

// File: rtl/mbox_cmd_ctrl.sv
module mbox_cmd_ctrl
    import mbox_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         cmd_wr,
    input  logic [31:0]  cmd_wdata,
    input  logic         done,
    input  logic         done_err,
    input  logic [7:0]   done_code,
    input  logic [7:0]   done_init,
    output cmd_word_t    cmd_q,
    output status_word_t status_q,
    output logic         req,
    output logic         irq
);

    cmd_word_t new_cmd;
    assign new_cmd = cmd_word_t'(cmd_wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q    <= '0;
            status_q <= '0;
            req      <= 1'b0;
            irq      <= 1'b0;
        end else begin
            req <= 1'b0;
            irq <= 1'b0;
            if (cmd_wr && status_q.busy) begin
                status_q.overrun <= 1'b1;
            end
            if (done && status_q.busy) begin
                status_q.busy     <= 1'b0;
                status_q.err      <= done_err;
                status_q.err_code <= done_code;
                status_q.init_id  <= done_init;
                irq               <= cmd_q.ioc;
            end else if (cmd_wr && !status_q.busy) begin
                cmd_q           <= new_cmd;
                status_q.busy   <= 1'b1;
                status_q.err    <= 1'b0;
                status_q.cmd_id <= new_cmd.cmd_id;
                req             <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/mbox_wordbuf.sv
module mbox_wordbuf #(
    parameter int WORDS = 4,
    parameter int IDX_W = 2,
    parameter int W     = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [W-1:0]     wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [W-1:0]     rdata
);

    logic [W-1:0] mem [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[g] <= '0;
            end else if (we && widx == IDX_W'(g)) begin
                mem[g] <= wdata;
            end
        end
    end

    assign rdata = mem[ridx];

endmodule

// File: rtl/mbox_host_rd.sv
module mbox_host_rd
    import mbox_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rd_en,
    input  logic        byte_mode,
    input  logic [1:0]  byte_sel,
    input  logic        stat_hit,
    input  logic        rbuf_hit,
    input  logic [31:0] stat_word,
    input  logic [31:0] rbuf_word,
    output logic [31:0] rdata
);

    logic [31:0] src_word;
    logic [31:0] rd_next;

    always_comb begin
        if (stat_hit) begin
            src_word = stat_word;
        end else if (rbuf_hit) begin
            src_word = rbuf_word;
        end else begin
            src_word = '0;
        end
        rd_next = byte_mode ? {24'b0, pick_byte(src_word, byte_sel)} : src_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_next;
        end
    end

endmodule

// File: rtl/mbox_regblk.sv
module mbox_regblk
    import mbox_pkg::*;
#(
    parameter int BUF_WORDS = 4,
    localparam int IDX_W = $clog2(BUF_WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             h_wr_en,
    input  logic             h_rd_en,
    input  logic             h_byte,
    input  logic [7:0]       h_addr,
    input  logic [31:0]      h_wdata,
    output logic [31:0]      h_rdata,
    output logic             host_irq,
    output logic             ctl_req,
    output logic [31:0]      ctl_cmd,
    input  logic [IDX_W-1:0] ctl_wbuf_idx,
    output logic [31:0]      ctl_wbuf_data,
    input  logic             ctl_rbuf_we,
    input  logic [IDX_W-1:0] ctl_rbuf_idx,
    input  logic [31:0]      ctl_rbuf_data,
    input  logic             ctl_done,
    input  logic             ctl_err,
    input  logic [7:0]       ctl_err_code,
    input  logic [7:0]       ctl_init_id
);

    logic             word_in_range;
    logic             cmd_hit;
    logic             stat_hit;
    logic             wbuf_hit;
    logic             rbuf_hit;
    logic [IDX_W-1:0] host_idx;
    logic [31:0]      rbuf_host_word;
    cmd_word_t        cmd_q;
    status_word_t     status_q;
    logic             busy;

    assign word_in_range = {1'b0, h_addr[3:2]} < 3'(BUF_WORDS);
    assign host_idx      = h_addr[IDX_W+1:2];
    assign cmd_hit       = h_addr == OFS_CMD;
    assign stat_hit      = h_addr[7:2] == OFS_STATUS[7:2];
    assign wbuf_hit      = h_addr[7:4] == WIN_WBUF && word_in_range;
    assign rbuf_hit      = h_addr[7:4] == WIN_RBUF && word_in_range;

    mbox_cmd_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_wr    (h_wr_en && cmd_hit),
        .cmd_wdata (h_wdata),
        .done      (ctl_done),
        .done_err  (ctl_err),
        .done_code (ctl_err_code),
        .done_init (ctl_init_id),
        .cmd_q     (cmd_q),
        .status_q  (status_q),
        .req       (ctl_req),
        .irq       (host_irq)
    );

    assign ctl_cmd = cmd_q;
    assign busy    = status_q.busy;

    mbox_wordbuf #(.WORDS(BUF_WORDS), .IDX_W(IDX_W), .W(32)) u_wbuf (
        .clk   (clk),
        .rst   (rst),
        .we    (h_wr_en && wbuf_hit),
        .widx  (host_idx),
        .wdata (h_wdata),
        .ridx  (ctl_wbuf_idx),
        .rdata (ctl_wbuf_data)
    );

    mbox_wordbuf #(.WORDS(BUF_WORDS), .IDX_W(IDX_W), .W(32)) u_rbuf (
        .clk   (clk),
        .rst   (rst),
        .we    (ctl_rbuf_we),
        .widx  (ctl_rbuf_idx),
        .wdata (ctl_rbuf_data),
        .ridx  (host_idx),
        .rdata (rbuf_host_word)
    );

    mbox_host_rd u_rd (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (h_rd_en),
        .byte_mode (h_byte),
        .byte_sel  (h_addr[1:0]),
        .stat_hit  (stat_hit),
        .rbuf_hit  (rbuf_hit),
        .stat_word (status_q),
        .rbuf_word (rbuf_host_word),
        .rdata     (h_rdata)
    );

endmodule

// File: rtl/mbox_regblk_chk.sv
module mbox_regblk_chk (
    input logic        clk,
    input logic        rst,
    input logic        h_wr_en,
    input logic [7:0]  h_addr,
    input logic        busy,
    input logic        overrun,
    input logic        ctl_req,
    input logic [31:0] ctl_cmd,
    input logic        ctl_done,
    input logic        host_irq
);

    logic cmd_wr;
    assign cmd_wr = h_wr_en && h_addr == 8'h00;

    // R2
    a_r2_accept: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !busy) |=> (busy && ctl_req));
    a_r2_req_pulse: assert property (@(posedge clk) disable iff (rst)
        ctl_req |=> !ctl_req);
    // R3
    a_r3_done_clears: assert property (@(posedge clk) disable iff (rst)
        (ctl_done && busy) |=> !busy);
    // R4
    a_r4_irq_pulse: assert property (@(posedge clk) disable iff (rst)
        host_irq |=> !host_irq);
    a_r4_irq_after_done: assert property (@(posedge clk) disable iff (rst)
        host_irq |-> $past(ctl_done && busy));
    // R5
    a_r5_busy_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && busy && !ctl_done) |=> ($stable(ctl_cmd) && !ctl_req && overrun));
    a_r5_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);
    // R9
    a_r9_idle_done: assert property (@(posedge clk) disable iff (rst)
        (ctl_done && !busy && !cmd_wr) |=> (!busy && !host_irq));

endmodule

bind mbox_regblk mbox_regblk_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .h_wr_en  (h_wr_en),
    .h_addr   (h_addr),
    .busy     (busy),
    .overrun  (status_q.overrun),
    .ctl_req  (ctl_req),
    .ctl_cmd  (ctl_cmd),
    .ctl_done (ctl_done),
    .host_irq (host_irq)
);

// File: tb/mbox_regblk_tb_top.sv
module mbox_regblk_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        h_wr_en = 1'b0, h_rd_en = 1'b0, h_byte = 1'b0;
    logic [7:0]  h_addr = '0;
    logic [31:0] h_wdata = '0;
    logic [31:0] h_rdata;
    logic        host_irq, ctl_req;
    logic [31:0] ctl_cmd, ctl_wbuf_data;
    logic [1:0]  ctl_wbuf_idx = '0, ctl_rbuf_idx = '0;
    logic        ctl_rbuf_we = 1'b0;
    logic [31:0] ctl_rbuf_data = '0;
    logic        ctl_done = 1'b0, ctl_err = 1'b0;
    logic [7:0]  ctl_err_code = '0, ctl_init_id = '0;

    int checks = 0;
    int fails  = 0;

    // bench model
    logic        m_busy = 0, m_err = 0, m_ovr = 0, m_ioc = 0;
    logic [3:0]  m_id = 0;
    logic [7:0]  m_code = 0, m_init = 0;
    logic [31:0] m_cmd = 0;
    logic [31:0] m_wbuf [4];
    logic [31:0] m_rbuf [4];

    always #4 clk = ~clk;

    mbox_regblk dut_i (
        .clk(clk), .rst(rst), .h_wr_en(h_wr_en), .h_rd_en(h_rd_en), .h_byte(h_byte),
        .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata), .host_irq(host_irq),
        .ctl_req(ctl_req), .ctl_cmd(ctl_cmd), .ctl_wbuf_idx(ctl_wbuf_idx),
        .ctl_wbuf_data(ctl_wbuf_data), .ctl_rbuf_we(ctl_rbuf_we), .ctl_rbuf_idx(ctl_rbuf_idx),
        .ctl_rbuf_data(ctl_rbuf_data), .ctl_done(ctl_done), .ctl_err(ctl_err),
        .ctl_err_code(ctl_err_code), .ctl_init_id(ctl_init_id)
    );

    function automatic logic [31:0] exp_status();
        return {8'h00, m_code, m_init, m_id, 1'b0, m_ovr, m_err, m_busy};
    endfunction

    function automatic logic [31:0] exp_rbuf_byte(input logic [3:0] n);
        return {24'h0, m_rbuf[n[3:2]][8*n[1:0] +: 8]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [7:0] a, input logic [31:0] d);
        logic accept;
        h_wr_en = 1; h_addr = a; h_wdata = d;
        @(negedge clk);
        h_wr_en = 0;
        if (a == 8'h00) begin
            accept = !m_busy;
            if (accept) begin
                m_cmd = d; m_busy = 1; m_err = 0; m_id = d[15:12]; m_ioc = d[8];
                chk("R2 ctl_req", {31'b0, ctl_req}, 32'd1);
                chk("R2 ctl_cmd", ctl_cmd, d);
            end else begin
                m_ovr = 1;
                chk("R5 no ctl_req", {31'b0, ctl_req}, 32'd0);
                chk("R5 ctl_cmd kept", ctl_cmd, m_cmd);
            end
        end else if (a[7:4] == 4'h8) begin
            m_wbuf[a[3:2]] = d;
        end
    endtask

    task automatic host_rd(input string req, input logic [7:0] a, input logic bm,
                           input logic [31:0] exp);
        h_rd_en = 1; h_addr = a; h_byte = bm;
        @(negedge clk);
        h_rd_en = 0; h_byte = 0;
        chk(req, h_rdata, exp);
    endtask

    task automatic ctl_finish(input logic e, input logic [7:0] code, input logic [7:0] ini);
        logic fire;
        fire = m_busy && m_ioc;
        ctl_done = 1; ctl_err = e; ctl_err_code = code; ctl_init_id = ini;
        @(negedge clk);
        ctl_done = 0;
        if (m_busy) begin
            m_busy = 0; m_err = e; m_code = code; m_init = ini;
            chk("R4 irq after done", {31'b0, host_irq}, {31'b0, fire});
        end else begin
            chk("R9 no irq when idle", {31'b0, host_irq}, 32'd0);
        end
        @(negedge clk);
        chk("R4 irq one cycle", {31'b0, host_irq}, 32'd0);
    endtask

    task automatic ctl_load(input logic [1:0] i, input logic [31:0] d);
        ctl_rbuf_we = 1; ctl_rbuf_idx = i; ctl_rbuf_data = d;
        @(negedge clk);
        ctl_rbuf_we = 0;
        m_rbuf[i] = d;
    endtask

    task automatic ctl_peek(input logic [1:0] i);
        ctl_wbuf_idx = i;
        #1;
        chk("R6 ctl_wbuf_data", ctl_wbuf_data, m_wbuf[i]);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd5150));
        for (int i = 0; i < 4; i++) begin m_wbuf[i] = 0; m_rbuf[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        chk("R1 host_irq", {31'b0, host_irq}, 32'd0);
        chk("R1 ctl_req", {31'b0, ctl_req}, 32'd0);
        host_rd("R1 status", 8'h04, 0, 32'd0);
        host_rd("R1 rbuf", 8'h98, 0, 32'd0);
        ctl_peek(2'd1);

        // R6 write buffer, R8 zero reads
        host_wr(8'h80, 32'h11223344);
        host_wr(8'h8C, 32'hA5A55A5A);
        ctl_peek(2'd0);
        ctl_peek(2'd3);
        host_rd("R8 wbuf reads zero", 8'h84, 0, 32'd0);
        host_rd("R8 cmd reads zero", 8'h00, 0, 32'd0);
        host_rd("R8 unmapped zero", 8'h40, 0, 32'd0);

        // R2/R3/R4 with IOC
        host_wr(8'h00, 32'h00087105);
        host_rd("R2 status busy", 8'h04, 0, exp_status());
        ctl_load(2'd1, 32'hDEADBEEF);
        ctl_finish(1'b1, 8'h3C, 8'h42);
        host_rd("R3 status done", 8'h04, 0, exp_status());
        host_rd("R7 rbuf word", 8'h94, 0, 32'hDEADBEEF);
        host_rd("R7 rbuf byte 6", 8'h96, 1, 32'h000000AD);
        host_rd("R7 rbuf byte 4", 8'h94, 1, 32'h000000EF);

        // R4 no IOC, R2 error cleared
        host_wr(8'h00, 32'h0000A0FF);
        host_rd("R2 err cleared", 8'h04, 0, exp_status());
        // R5 overrun
        host_wr(8'h00, 32'h0000F1EE);
        host_rd("R5 status kept", 8'h04, 0, exp_status());
        ctl_finish(1'b0, 8'h00, 8'h07);
        host_rd("R5 overrun sticky", 8'h04, 0, exp_status());
        // R9 idle done
        ctl_finish(1'b1, 8'hFF, 8'hFF);
        host_rd("R9 idle done ignored", 8'h04, 0, exp_status());

        // random mix
        for (int it = 0; it < 600; it++) begin
            automatic int op = $urandom % 8;
            automatic logic [31:0] r = $urandom;
            automatic logic [3:0] n = 4'($urandom);
            case (op)
                0: host_wr(8'h00, r);
                1: ctl_finish(r[0], r[15:8], r[23:16]);
                2: host_wr({4'h8, n[3:2], 2'b00}, r);
                3: ctl_load(n[1:0], r);
                4: host_rd("R3 status rand", 8'h04, 0, exp_status());
                5: host_rd("R7 rbuf word rand", {4'h9, n[3:2], 2'b00}, 0, m_rbuf[n[3:2]]);
                6: host_rd("R7 rbuf byte rand", {4'h9, n}, 1, exp_rbuf_byte(n));
                default: ctl_peek(n[1:0]);
            endcase
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule